// File: doc/BRIEF.md
# Sticky Event Registers and Interrupt Summary for a Four-Port Power Controller

This block collects single-cycle event pulses from the four ports of a power-sourcing controller, along with a handful of supply-health events, and holds each one in a sticky bit until the host acknowledges it. Events are grouped into five 8-bit registers: power changes, detect/class completion, faults, start-up timeouts and supply. Each register answers at two addresses. The even address is a plain read. The odd address returns the same byte and empties the register as part of the same access.

An 8-bit summary byte is formed by ORing 4-bit port groups of the event registers. A host-writable mask selects which summary bits may pull the active-low interrupt pin. The pin falls when an unmasked summary bit goes from 0 to 1, and it rises again once no unmasked summary bit remains set.

A plain address/read-enable/write-enable interface gives the host access to all of this. Read data is combinational from the address, and a clear-on-read takes effect at the clock edge on which `rd_en` is high.

Top module: `evt_irq_hub`

## Requirements
- R1: A 1 on any event pulse input sets its event bit at the next clock edge, and the bit stays 1 until a clear-on-read, a clear-all, or reset removes it.
- R2: A read at the even addresses 0x2 (power), 0x4 (detect/class), 0x6 (fault), 0x8 (start-up) and 0xA (supply) returns the register and never clears it.
- R3: A read at the odd address one above each of those (0x3, 0x5, 0x7, 0x9, 0xB) returns the same byte as its even partner and clears that register at the clock edge, so both addresses then read 0.
- R4: An event pulse that arrives in the same cycle as a clear-on-read of its register leaves its bit set after that edge.
- R5: The event registers have these field layouts:
  - power: bits 3:0 hold power-enable changes for ports 0–3, and bits 7:4 hold power-good changes.
  - detect/class: bits 3:0 hold detect-complete, and bits 7:4 hold class-complete.
  - fault: bits 3:0 hold overcurrent timeouts, and bits 7:4 hold disconnects.
  - start-up: bits 3:0 hold start-up timeouts, and bits 7:4 always read 0.
  - supply: only input bits 1 (oscillator fail), 4, 5 and 7 are captured, and every other bit reads 0.
  - Address 0xD and addresses 0xE–0xF read 0.
- R6: The summary byte at address 0x0 is read-only, and a write to it has no effect. Its bit N is 1 when any bit in group N is set, with the groups as follows:
  - bit 0: power-enable changes
  - bit 1: power-good changes
  - bit 2: detect-complete
  - bit 3: class-complete
  - bit 4: disconnect
  - bit 5: overcurrent
  - bit 6: start-up
  - bit 7: supply
- R7: Summary bit 7 is the OR of supply bits 7, 5 and 4, plus supply bit 1 only while bit 0 of the configuration register at 0xC is 1. That configuration bit is read/write and resets to 1.
- R8: The mask at address 0x1 is read/write. It resets to 0x80 when `auto_strap` is low during reset and to 0xE8 when it is high. The mask never changes the summary byte.
- R9: `irq_n` goes low one clock after a summary bit whose mask bit is 1 changes from 0 to 1. Unmasking a summary bit that is already 1 does not pull the pin low. Once no summary bit with its mask bit set remains 1, `irq_n` returns high one clock later.
- R10: Writing a byte with bit 7 set to address 0xD clears all five event registers at that clock edge. Event pulses arriving in the same cycle are kept.
- R11: After reset, all event registers and the summary read 0, the configuration bit reads 1, and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_strap | input | 1 | Strap input that picks the mask reset value |
| pwr_en_chg | input | 4 | Per-port power-enable change pulses |
| pwr_good_chg | input | 4 | Per-port power-good change pulses |
| det_done | input | 4 | Per-port detect-complete pulses |
| cls_done | input | 4 | Per-port class-complete pulses |
| discon | input | 4 | Per-port disconnect pulses |
| ocur_tmo | input | 4 | Per-port overcurrent timeout pulses |
| start_tmo | input | 4 | Per-port start-up timeout pulses |
| sup_evt | input | 8 | Supply event pulses; only bits 1, 4, 5, 7 are used |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe; clears the register at odd event addresses |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
A sticky bit lost or wrongly cleared shows on `rdata` at the next read of either address of that register. It also shows in the summary byte in the same cycle. A wrong rise detector or a wrong mask path shows at `irq_n` one clock after the summary changes, because the pin is a single register away from the summary. The clear-on-read race and unmasking an already-set bit are hit by directed cases. Random reads, writes and pulses are checked on every cycle against a model built from the requirements.

// File: rtl/evt_irq_hub.sv
module evt_irq_hub #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_strap,
  input  logic [3:0]    pwr_en_chg,
  input  logic [3:0]    pwr_good_chg,
  input  logic [3:0]    det_done,
  input  logic [3:0]    cls_done,
  input  logic [3:0]    discon,
  input  logic [3:0]    ocur_tmo,
  input  logic [3:0]    start_tmo,
  input  logic [7:0]    sup_evt,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq_n
);
  localparam int NREG = 5;
  localparam logic [AW-1:0] A_SUM  = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_CFG  = AW'(12);
  localparam logic [AW-1:0] A_PB   = AW'(13);
  localparam logic [7:0] SUP_KEEP = 8'b1011_0010;
  localparam logic [7:0] MASK_LO  = 8'h80;
  localparam logic [7:0] MASK_HI  = 8'hE8;

  logic [7:0] ev_q [NREG];
  logic [7:0] set_v [NREG];
  logic [NREG-1:0] cor_v;
  logic [7:0] mask_q, irq, irq_q;
  logic osc_en, hold, sup_hit;

  wire clr_all = wr_en && (addr == A_PB) && wdata[7];

  assign set_v[0] = {pwr_good_chg, pwr_en_chg};
  assign set_v[1] = {cls_done, det_done};
  assign set_v[2] = {discon, ocur_tmo};
  assign set_v[3] = {4'b0000, start_tmo};
  assign set_v[4] = sup_evt & SUP_KEEP;

  always_comb
    for (int i = 0; i < NREG; i++)
      cor_v[i] = rd_en && (addr == AW'(2 * i + 3));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) ev_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        ev_q[i] <= ((clr_all || cor_v[i]) ? 8'h00 : ev_q[i]) | set_v[i];
    end

  assign sup_hit = |(ev_q[4] & {1'b1, 1'b0, 1'b1, 1'b1, 2'b00, osc_en, 1'b0});

  assign irq = {sup_hit,
                |ev_q[3][3:0],
                |ev_q[2][3:0],
                |ev_q[2][7:4],
                |ev_q[1][7:4],
                |ev_q[1][3:0],
                |ev_q[0][7:4],
                |ev_q[0][3:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q <= auto_strap ? MASK_HI : MASK_LO;
      osc_en <= 1'b1;
    end else if (wr_en) begin
      if (addr == A_MASK) mask_q <= wdata;
      if (addr == A_CFG)  osc_en <= wdata[0];
    end

  wire [7:0] rise = irq & ~irq_q & mask_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_q <= '0;
      hold  <= 1'b0;
    end else begin
      irq_q <= irq;
      if (|rise)                hold <= 1'b1;
      else if (!(|(irq & mask_q))) hold <= 1'b0;
    end

  assign irq_n = ~hold;

  always_comb begin
    rdata = '0;
    case (addr)
      A_SUM:  rdata = irq;
      A_MASK: rdata = mask_q;
      A_CFG:  rdata = {7'b0, osc_en};
      default:
        for (int i = 0; i < NREG; i++)
          if (addr[AW-1:1] == (AW-1)'(i + 1)) rdata = ev_q[i];
    endcase
  end
endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd_en,
  input logic          wr_en,
  input logic          wdata_7,
  input logic [3:0]    pwr_en_chg,
  input logic [3:0]    pwr_good_chg,
  input logic [7:0]    pwr_q,
  input logic [7:0]    irq,
  input logic [7:0]    mask_q,
  input logic          irq_n
);
  localparam logic [AW-1:0] A_PWR   = AW'(2);
  localparam logic [AW-1:0] A_PWR_C = AW'(3);
  localparam logic [AW-1:0] A_PB    = AW'(13);

  AST_PULSE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|pwr_en_chg) |=> ((pwr_q[3:0] & $past(pwr_en_chg)) == $past(pwr_en_chg))); // R1

  AST_EVEN_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_PWR && !wr_en) |=> ((pwr_q & $past(pwr_q)) == $past(pwr_q))); // R2

  AST_COR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_PWR_C && !(|pwr_en_chg) && !(|pwr_good_chg)) |=> (pwr_q == 8'h00)); // R3

  AST_COR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_PWR_C && (|pwr_en_chg)) |=> (pwr_q[3:0] != 4'h0)); // R4

  AST_PIN_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq & ~$past(irq) & mask_q)) |=> !irq_n); // R9

  AST_PIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & mask_q) == 8'h00) |=> irq_n); // R9

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PB && wdata_7 && !(|pwr_en_chg) && !(|pwr_good_chg)) |=> (pwr_q == 8'h00)); // R10
endmodule

bind evt_irq_hub evt_irq_hub_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata_7(wdata[7]), .pwr_en_chg(pwr_en_chg), .pwr_good_chg(pwr_good_chg),
  .pwr_q(ev_q[0]), .irq(irq), .mask_q(mask_q), .irq_n(irq_n)
);

// File: tb/evt_irq_hub_tb_top.sv
module evt_irq_hub_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_strap = 1'b0;
  logic [3:0] s_pen = '0, s_pgd = '0, s_det = '0, s_cls = '0, s_dis = '0, s_ocr = '0, s_stt = '0;
  logic [7:0] s_sup = '0;
  logic [3:0] addr = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_n;

  int n_chk = 0, n_fail = 0;

  logic [7:0] ev_m [5];
  logic [7:0] mask_m, irqq_m;
  logic cfg_m, hold_m;

  always #10 clk = ~clk;

  evt_irq_hub dut_i (
    .clk(clk), .rst_n(rst_n), .auto_strap(auto_strap),
    .pwr_en_chg(s_pen), .pwr_good_chg(s_pgd), .det_done(s_det), .cls_done(s_cls),
    .discon(s_dis), .ocur_tmo(s_ocr), .start_tmo(s_stt), .sup_evt(s_sup),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] summ_m();
    logic s7;
    s7 = ev_m[4][7] | ev_m[4][5] | ev_m[4][4] | (ev_m[4][1] & cfg_m);
    return {s7, |ev_m[3][3:0], |ev_m[2][3:0], |ev_m[2][7:4],
            |ev_m[1][7:4], |ev_m[1][3:0], |ev_m[0][7:4], |ev_m[0][3:0]};
  endfunction

  function automatic logic [7:0] rd_m(input logic [3:0] a);
    if (a == 4'd0)  return summ_m();
    if (a == 4'd1)  return mask_m;
    if (a == 4'd12) return {7'b0, cfg_m};
    if (a >= 4'd2 && a <= 4'd11) return ev_m[(a >> 1) - 1];
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a == 4'd0) return "R6";
    if (a == 4'd1) return "R8";
    if (a == 4'd12) return "R7";
    if (a >= 4'd2 && a <= 4'd11) return a[0] ? "R3" : "R2";
    return "R5";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 5; i++) ev_m[i] = '0;
    mask_m = auto_strap ? 8'hE8 : 8'h80;
    cfg_m = 1'b1; hold_m = 1'b0; irqq_m = '0;
  endtask

  task automatic model_edge();
    logic [7:0] s, setv [5];
    logic clr_all;
    s = summ_m();
    if (|(s & ~irqq_m & mask_m)) hold_m = 1'b1;
    else if ((s & mask_m) == 8'h00) hold_m = 1'b0;
    irqq_m = s;
    clr_all = wr_en && addr == 4'd13 && wdata[7];
    setv[0] = {s_pgd, s_pen}; setv[1] = {s_cls, s_det}; setv[2] = {s_dis, s_ocr};
    setv[3] = {4'h0, s_stt};  setv[4] = s_sup & 8'hB2;
    for (int i = 0; i < 5; i++)
      ev_m[i] = ((clr_all || (rd_en && addr == 4'(2 * i + 3))) ? 8'h00 : ev_m[i]) | setv[i];
    if (wr_en && addr == 4'd1)  mask_m = wdata;
    if (wr_en && addr == 4'd12) cfg_m = wdata[0];
  endtask

  task automatic cyc();
    #2;
    chk(tag_of(addr), rdata, rd_m(addr));
    chk("R9", {7'b0, irq_n}, {7'b0, ~hold_m});
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic quiet();
    s_pen = '0; s_pgd = '0; s_det = '0; s_cls = '0; s_dis = '0; s_ocr = '0; s_stt = '0; s_sup = '0;
    rd_en = 1'b0; wr_en = 1'b0; wdata = '0;
  endtask

  task automatic idle(input int n);
    quiet();
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic peek(input logic [3:0] a, input logic [7:0] exp, input string tag);
    quiet(); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic do_rd(input logic [3:0] a);
    quiet(); addr = a; rd_en = 1'b1; cyc(); quiet();
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    quiet(); addr = a; wr_en = 1'b1; wdata = d; cyc(); quiet();
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; auto_strap = strap; quiet();
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset(1'b0);
    // R11 reset state and R8 low-strap mask
    peek(4'd1, 8'h80, "R8");
    peek(4'd0, 8'h00, "R11");
    peek(4'd12, 8'h01, "R11");
    for (int a = 2; a < 12; a++) peek(4'(a), 8'h00, "R11");
    chk("R11", {7'b0, irq_n}, 8'h01);

    // R1 sticky
    s_det = 4'b0100; cyc(); idle(3);
    peek(4'd4, 8'h04, "R1");
    // R2 even read keeps
    do_rd(4'd4); peek(4'd4, 8'h04, "R2");
    // R3 odd read returns then clears both
    peek(4'd5, 8'h04, "R3");
    do_rd(4'd5); peek(4'd4, 8'h00, "R3"); peek(4'd5, 8'h00, "R3");
    // R4 pulse during clear-on-read survives
    quiet(); addr = 4'd5; rd_en = 1'b1; s_cls = 4'b0001; s_det = 4'b0010; cyc(); quiet();
    peek(4'd4, 8'h12, "R4");
    // R5 field layouts
    s_ocr = 4'b0001; s_dis = 4'b1000; cyc(); quiet();
    peek(4'd6, 8'h81, "R5");
    s_stt = 4'hF; cyc(); quiet();
    peek(4'd8, 8'h0F, "R5");
    s_sup = 8'hFF; cyc(); quiet();
    peek(4'd10, 8'hB2, "R5");
    s_pen = 4'b0010; s_pgd = 4'b0100; cyc(); quiet();
    peek(4'd2, 8'h42, "R5");
    peek(4'd13, 8'h00, "R5");
    // R6 summary layout and read-only
    peek(4'd0, 8'hFF, "R6");
    do_rd(4'd3); do_rd(4'd5);
    peek(4'd0, 8'hF0, "R6");
    do_wr(4'd0, 8'h00); peek(4'd0, 8'hF0, "R6");
    // R7 oscillator-fail term gated by config bit 0
    do_rd(4'd11); s_sup = 8'h02; cyc(); quiet();
    peek(4'd0, 8'hF0, "R7");
    do_wr(4'd12, 8'h00); peek(4'd0, 8'h70, "R7"); peek(4'd12, 8'h00, "R7");
    do_wr(4'd12, 8'h01); peek(4'd0, 8'hF0, "R7");
    // R8 mask read/write, no effect on summary
    do_wr(4'd1, 8'h00); peek(4'd1, 8'h00, "R8"); peek(4'd0, 8'hF0, "R8");
    // R10 clear all
    s_pen = 4'hF; cyc(); quiet();
    do_wr(4'd13, 8'h80);
    for (int a = 2; a < 12; a++) peek(4'(a), 8'h00, "R10");
    peek(4'd0, 8'h00, "R10");
    // R9 pin behaviour
    idle(2);
    s_pen = 4'b0001; cyc(); idle(2);
    chk("R9", {7'b0, irq_n}, 8'h01);
    do_wr(4'd1, 8'h01); idle(2);
    chk("R9", {7'b0, irq_n}, 8'h01);
    do_rd(4'd3); idle(1);
    s_pen = 4'b0001; cyc(); quiet(); #1;
    chk("R9", {7'b0, irq_n}, 8'h01);
    cyc(); #1;
    chk("R9", {7'b0, irq_n}, 8'h00);
    do_rd(4'd3); #1;
    chk("R9", {7'b0, irq_n}, 8'h00);
    cyc(); #1;
    chk("R9", {7'b0, irq_n}, 8'h01);
    // R8 high-strap mask
    do_reset(1'b1);
    peek(4'd1, 8'hE8, "R8");
    chk("R11", {7'b0, irq_n}, 8'h01);

    // random traffic checked against the model
    for (int n = 0; n < 4000; n++) begin
      s_pen = 4'($urandom) & 4'($urandom) & 4'($urandom);
      s_pgd = 4'($urandom) & 4'($urandom) & 4'($urandom);
      s_det = 4'($urandom) & 4'($urandom) & 4'($urandom);
      s_cls = 4'($urandom) & 4'($urandom) & 4'($urandom);
      s_dis = 4'($urandom) & 4'($urandom) & 4'($urandom);
      s_ocr = 4'($urandom) & 4'($urandom) & 4'($urandom);
      s_stt = 4'($urandom) & 4'($urandom) & 4'($urandom);
      s_sup = 8'($urandom) & 8'($urandom) & 8'($urandom);
      if ($urandom % 3 == 0) begin
        s_pen = '0; s_pgd = '0; s_det = '0; s_cls = '0;
        s_dis = '0; s_ocr = '0; s_stt = '0; s_sup = '0;
      end
      addr  = 4'($urandom);
      rd_en = 1'($urandom);
      wr_en = ($urandom % 6) == 0;
      wdata = 8'($urandom);
      cyc();
    end
    quiet();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule